// File: doc/BRIEF.md
# Single-Pad Bus-Controlled I/O Cell Controller

This block controls one I/O pad and is configured over a Wishbone bus. It sits between an internal peripheral and the pad. The peripheral uses four signals: input disable, output disable, output value and input value. These pass straight through to the pad unless software has asked for a register override. Software also writes the pad mode bits, which set the pad's other electrical options.

One copy is built for each pad, and each copy gets its pad index as a parameter. A copy answers only at the word address `BASE_ADDR + 4*PAD_INDEX`. When it is not answering, it drives zero on read data and holds acknowledge low. The read-data and acknowledge outputs of every copy can therefore be OR-ed into one shared return path, and the whole group then appears to the bus as a single slave.

The override enables, override values and pad mode all share one 32-bit word. A synchronous reset loads all of them from parameters.

Top module: `pad_wb_gpio`

## Requirements
- R1: A copy acknowledges and writes only when `wb_adr_i[31:2]` equals `(BASE_ADDR + 4*PAD_INDEX) >> 2`. Any other address gives no acknowledge and leaves the configuration unchanged.
- R2: A request is `wb_cyc_i` and `wb_stb_i` high together at the matching address. The acknowledge rises in the cycle after the request, stays high for one cycle only, and never stays high for two cycles in a row, even while the request is held.
- R3: While `wb_ack_o` is low, `wb_dat_o` is all zero, so several copies can be OR-ed onto shared return lines.
- R4: The register word has this layout:
  - bits [2:0] are the override enables, in the order output disable, output value, input value.
  - bits [10:8] are the override values, in the same order.
  - bit 15 is the live pad input and is read-only.
  - bits [16 +: MODE_W] are the pad mode.
  - all other bits read as zero.
- R5: A write updates only the bytes whose `wb_sel_i` bit is set. A write with `wb_sel_i` = 0 changes nothing.
- R6: While `rst_i` is high at a clock edge, the pad mode is loaded from `RESET_MODE`, and the override enables and values are loaded from `RESET_OVR_EN` and `RESET_OVR_VAL`.
- R7: With an override enable clear, the pad receives the peripheral's output disable and output value, and the peripheral receives the pad input.
- R8: Each override bit acts on its own signal. When it is set, its signal takes the matching override value, whatever the other two bits are.
- R9: Input disable always passes from the peripheral to the pad unchanged.
- R10: A read returns the current configuration together with the pad input as sampled in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_sel_i | input | 4 | Byte selects |
| wb_adr_i | input | 32 | Byte address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, zero unless acknowledging |
| wb_ack_o | output | 1 | One-cycle acknowledge |
| fn_ieb_i | input | 1 | Peripheral input disable |
| fn_oeb_i | input | 1 | Peripheral output disable |
| fn_out_i | input | 1 | Peripheral output value |
| fn_in_o | output | 1 | Input value returned to the peripheral |
| pad_ieb_o | output | 1 | Input disable sent to the pad |
| pad_oeb_o | output | 1 | Output disable sent to the pad |
| pad_out_o | output | 1 | Output value sent to the pad |
| pad_in_i | input | 1 | Value read from the pad |
| pad_mode_o | output | MODE_W | Pad mode bits |

## Verification
Two functions can fall in the same cycle:
- A bus write that changes the override registers can be acknowledged in the same cycle that the peripheral toggles its signals.
- A read's acknowledge can coincide with a change on the pad input.

The bench provokes the first by writing every combination of override enable and value, then sweeping all peripheral and pad input patterns against the new setting. It provokes the second by setting the pad input before the read and comparing bit 15 with that value.

Two copies with different indices share OR-ed return lines. The bench checks that an address sweep makes exactly the right copy answer.

// File: rtl/pad_wb_gpio_pkg.sv
package pad_wb_gpio_pkg;

    localparam int OVR_W       = 3;
    localparam int OVR_OEB     = 0;
    localparam int OVR_OUT     = 1;
    localparam int OVR_IN      = 2;
    localparam int EN_LSB      = 0;
    localparam int VAL_LSB     = 8;
    localparam int LIVE_IN_BIT = 15;
    localparam int MODE_LSB    = 16;
    localparam int BUS_W       = 32;
    localparam int SEL_W       = BUS_W / 8;

    typedef logic [OVR_W-1:0] ovr_vec_t;

endpackage

// File: rtl/pad_wb_decode.sv
module pad_wb_decode #(
    parameter logic [31:0] BASE_ADDR = 32'h2100_0000,
    parameter int          PAD_INDEX = 0
) (
    input  logic [31:0] adr_i,
    input  logic        cyc_i,
    input  logic        stb_i,
    output logic        hit_o
);
    localparam logic [31:0] MY_ADDR = BASE_ADDR + 32'(4 * PAD_INDEX);
    localparam logic [29:0] MY_WORD = MY_ADDR[31:2];

    always_comb begin
        hit_o = cyc_i && stb_i && (adr_i[31:2] == MY_WORD);
    end
endmodule

// File: rtl/pad_cfg_regs.sv
module pad_cfg_regs
    import pad_wb_gpio_pkg::*;
#(
    parameter int             MODE_W        = 13,
    parameter logic [MODE_W-1:0] RESET_MODE = '0,
    parameter ovr_vec_t       RESET_OVR_EN  = '0,
    parameter ovr_vec_t       RESET_OVR_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             hit_i,
    input  logic             cyc_i,
    input  logic             stb_i,
    input  logic             we_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [BUS_W-1:0] dat_i,
    input  logic             pad_in_i,
    output logic             ack_o,
    output logic [BUS_W-1:0] rd_o,
    output ovr_vec_t         ovr_en_o,
    output ovr_vec_t         ovr_val_o,
    output logic [MODE_W-1:0] mode_o
);
    typedef struct packed {
        logic              ack;
        ovr_vec_t          ovr_en;
        ovr_vec_t          ovr_val;
        logic [MODE_W-1:0] mode;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic [BUS_W-1:0] cur_word;
    logic [BUS_W-1:0] new_word;
    logic [BUS_W-1:0] byte_mask;
    logic             req;

    genvar b;
    generate
        for (b = 0; b < SEL_W; b++) begin : g_mask
            assign byte_mask[8*b +: 8] = {8{sel_i[b]}};
        end
    endgenerate

    always_comb begin
        cur_word = '0;
        cur_word[EN_LSB +: OVR_W]    = st_q.ovr_en;
        cur_word[VAL_LSB +: OVR_W]   = st_q.ovr_val;
        cur_word[MODE_LSB +: MODE_W] = st_q.mode;
        new_word = (cur_word & ~byte_mask) | (dat_i & byte_mask);
        req      = hit_i && !st_q.ack;

        st_d     = st_q;
        st_d.ack = req;
        if (req && we_i) begin
            st_d.ovr_en  = new_word[EN_LSB +: OVR_W];
            st_d.ovr_val = new_word[VAL_LSB +: OVR_W];
            st_d.mode    = new_word[MODE_LSB +: MODE_W];
        end
        if (rst_i) begin
            st_d.ack     = 1'b0;
            st_d.ovr_en  = RESET_OVR_EN;
            st_d.ovr_val = RESET_OVR_VAL;
            st_d.mode    = RESET_MODE;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    always_comb begin
        rd_o = '0;
        if (st_q.ack) begin
            rd_o              = cur_word;
            rd_o[LIVE_IN_BIT] = pad_in_i;
        end
    end

    assign ack_o     = st_q.ack;
    assign ovr_en_o  = st_q.ovr_en;
    assign ovr_val_o = st_q.ovr_val;
    assign mode_o    = st_q.mode;

    assert_ack_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.ack |=> !st_q.ack);

    assert_ack_after_req_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(st_q.ack) |-> $past(cyc_i && stb_i));

    assert_reset_load_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (st_q.mode == RESET_MODE && st_q.ovr_en == RESET_OVR_EN
                          && st_q.ovr_val == RESET_OVR_VAL));

    assert_empty_sel_keeps_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (req && we_i && sel_i == '0) |=> ($stable(st_q.mode) && $stable(st_q.ovr_en)
                                          && $stable(st_q.ovr_val)));
endmodule

// File: rtl/pad_sig_mux.sv
module pad_sig_mux
    import pad_wb_gpio_pkg::*;
(
    input  ovr_vec_t ovr_en_i,
    input  ovr_vec_t ovr_val_i,
    input  logic     fn_ieb_i,
    input  logic     fn_oeb_i,
    input  logic     fn_out_i,
    input  logic     pad_in_i,
    output logic     fn_in_o,
    output logic     pad_ieb_o,
    output logic     pad_oeb_o,
    output logic     pad_out_o
);
    ovr_vec_t src, res;

    always_comb begin
        src          = '0;
        src[OVR_OEB] = fn_oeb_i;
        src[OVR_OUT] = fn_out_i;
        src[OVR_IN]  = pad_in_i;
    end

    genvar i;
    generate
        for (i = 0; i < OVR_W; i++) begin : g_ovr
            assign res[i] = ovr_en_i[i] ? ovr_val_i[i] : src[i];
        end
    endgenerate

    assign pad_oeb_o = res[OVR_OEB];
    assign pad_out_o = res[OVR_OUT];
    assign fn_in_o   = res[OVR_IN];
    assign pad_ieb_o = fn_ieb_i;
endmodule

// File: rtl/pad_wb_gpio.sv
module pad_wb_gpio
    import pad_wb_gpio_pkg::*;
#(
    parameter logic [31:0]       BASE_ADDR     = 32'h2100_0000,
    parameter int                PAD_INDEX     = 0,
    parameter int                MODE_W        = 13,
    parameter logic [MODE_W-1:0] RESET_MODE    = 13'h0403,
    parameter ovr_vec_t          RESET_OVR_EN  = '0,
    parameter ovr_vec_t          RESET_OVR_VAL = '0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [3:0]        wb_sel_i,
    input  logic [31:0]       wb_adr_i,
    input  logic [31:0]       wb_dat_i,
    output logic [31:0]       wb_dat_o,
    output logic              wb_ack_o,
    input  logic              fn_ieb_i,
    input  logic              fn_oeb_i,
    input  logic              fn_out_i,
    output logic              fn_in_o,
    output logic              pad_ieb_o,
    output logic              pad_oeb_o,
    output logic              pad_out_o,
    input  logic              pad_in_i,
    output logic [MODE_W-1:0] pad_mode_o
);
    localparam logic [31:0] MY_ADDR = BASE_ADDR + 32'(4 * PAD_INDEX);

    logic     hit;
    ovr_vec_t ovr_en, ovr_val;

    pad_wb_decode #(.BASE_ADDR(BASE_ADDR), .PAD_INDEX(PAD_INDEX)) u_decode (
        .adr_i(wb_adr_i), .cyc_i(wb_cyc_i), .stb_i(wb_stb_i), .hit_o(hit)
    );

    pad_cfg_regs #(
        .MODE_W(MODE_W), .RESET_MODE(RESET_MODE),
        .RESET_OVR_EN(RESET_OVR_EN), .RESET_OVR_VAL(RESET_OVR_VAL)
    ) u_regs (
        .clk_i(clk_i), .rst_i(rst_i), .hit_i(hit), .cyc_i(wb_cyc_i),
        .stb_i(wb_stb_i), .we_i(wb_we_i), .sel_i(wb_sel_i), .dat_i(wb_dat_i),
        .pad_in_i(pad_in_i), .ack_o(wb_ack_o), .rd_o(wb_dat_o),
        .ovr_en_o(ovr_en), .ovr_val_o(ovr_val), .mode_o(pad_mode_o)
    );

    pad_sig_mux u_mux (
        .ovr_en_i(ovr_en), .ovr_val_i(ovr_val), .fn_ieb_i(fn_ieb_i),
        .fn_oeb_i(fn_oeb_i), .fn_out_i(fn_out_i), .pad_in_i(pad_in_i),
        .fn_in_o(fn_in_o), .pad_ieb_o(pad_ieb_o), .pad_oeb_o(pad_oeb_o),
        .pad_out_o(pad_out_o)
    );

    assert_ack_own_address_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(wb_ack_o) |-> $past(wb_adr_i[31:2] == MY_ADDR[31:2]));

    assert_ack_dataless_idle_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(wb_ack_o) |-> (wb_dat_o == '0));
endmodule

// File: tb/test_pad_wb_gpio.sv
module test_pad_wb_gpio;
    localparam logic [31:0] BASE = 32'h2100_0000;
    localparam int MW  = 13;
    localparam logic [MW-1:0] RMODE_A = 13'h1A5B;
    localparam logic [MW-1:0] RMODE_B = 13'h0403;
    localparam int IDX_A = 2;
    localparam int IDX_B = 5;
    localparam logic [31:0] WMASK = 32'h1FFF_0707;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc = 0, stb = 0, we = 0;
    logic [3:0]  sel = 0;
    logic [31:0] adr = 0, wdat = 0;
    logic fn_ieb = 0, fn_oeb = 0, fn_out = 0, pin = 0;
    logic [31:0] dat_a, dat_b;
    logic ack_a, ack_b;
    logic fin_a, ieb_a, oeb_a, out_a;
    logic fin_b, ieb_b, oeb_b, out_b;
    logic [MW-1:0] mode_a, mode_b;
    int checks = 0, fails = 0;
    bit finished = 0;
    logic [31:0] model_a;

    wire [31:0] dat_bus = dat_a | dat_b;
    wire        ack_bus = ack_a | ack_b;

    always #10 clk = ~clk;

    pad_wb_gpio #(.BASE_ADDR(BASE), .PAD_INDEX(IDX_A), .MODE_W(MW), .RESET_MODE(RMODE_A))
    i_pad_wb_gpio (
        .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_sel_i(sel), .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(dat_a),
        .wb_ack_o(ack_a), .fn_ieb_i(fn_ieb), .fn_oeb_i(fn_oeb), .fn_out_i(fn_out),
        .fn_in_o(fin_a), .pad_ieb_o(ieb_a), .pad_oeb_o(oeb_a), .pad_out_o(out_a),
        .pad_in_i(pin), .pad_mode_o(mode_a)
    );

    pad_wb_gpio #(.BASE_ADDR(BASE), .PAD_INDEX(IDX_B), .MODE_W(MW), .RESET_MODE(RMODE_B))
    i_pad_wb_gpio_b (
        .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_sel_i(sel), .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(dat_b),
        .wb_ack_o(ack_b), .fn_ieb_i(fn_ieb), .fn_oeb_i(fn_oeb), .fn_out_i(fn_out),
        .fn_in_o(fin_b), .pad_ieb_o(ieb_b), .pad_oeb_o(oeb_b), .pad_out_o(out_b),
        .pad_in_i(pin), .pad_mode_o(mode_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] d, logic [3:0] s);
        logic [31:0] m;
        for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{s[k]}};
        return ((old & ~m) | (d & m)) & WMASK;
    endfunction

    // one request cycle; returns OR-ed ack and data seen in the following cycle
    task automatic xfer(input logic w, input logic [31:0] a, input logic [3:0] s,
                        input logic [31:0] d, output logic [31:0] rd, output logic [1:0] acks);
        @(negedge clk);
        cyc = 1; stb = 1; we = w; adr = a; sel = s; wdat = d;
        @(negedge clk);
        cyc = 0; stb = 0; we = 0;
        rd = dat_bus; acks = {ack_b, ack_a};
        @(negedge clk);
        chk("R2 ack drops", {31'b0, ack_bus}, 32'd0);
        chk("R3 idle data zero", dat_bus, 32'd0);
    endtask

    task automatic read_a(output logic [31:0] rd);
        logic [1:0] ak;
        xfer(1'b0, BASE + 4*IDX_A, 4'hF, 32'h0, rd, ak);
        chk("R1 read ack from A only", {30'b0, ak}, 32'd1);
    endtask

    task automatic write_a(input logic [31:0] d, input logic [3:0] s);
        logic [31:0] rd;
        logic [1:0] ak;
        xfer(1'b1, BASE + 4*IDX_A, s, d, rd, ak);
        chk("R1 write ack from A only", {30'b0, ak}, 32'd1);
        model_a = merge(model_a, d, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [1:0] ak;
        int ackcnt;
        repeat (3) @(negedge clk);
        rst = 0;
        model_a = {3'b0, RMODE_A, 16'h0};

        // R6 reset state
        chk("R6 reset mode A", {19'b0, mode_a}, {19'b0, RMODE_A});
        chk("R6 reset mode B", {19'b0, mode_b}, {19'b0, RMODE_B});
        chk("R3 reset ack low", {31'b0, ack_bus}, 32'd0);
        pin = 1;
        read_a(rd);
        chk("R10 R4 reset readback", rd, model_a | 32'h8000);
        pin = 0;
        read_a(rd);
        chk("R10 live input low", rd, model_a);

        // R1 address sweep with both copies on shared lines
        for (int k = 0; k < 8; k++) begin
            for (int lo = 0; lo < 4; lo++) begin
                xfer(1'b1, BASE + 4*k + lo, 4'hF, 32'hFFFF_FFFF, rd, ak);
                chk("R1 decode sweep", {30'b0, ak},
                    {30'b0, (k == IDX_B) ? 2'b10 : (k == IDX_A) ? 2'b01 : 2'b00});
                if (k == IDX_A) model_a = merge(model_a, 32'hFFFF_FFFF, 4'hF);
            end
        end
        xfer(1'b1, BASE + 32'h100 + 4*IDX_A, 4'hF, 32'h0, rd, ak);
        chk("R1 far alias ignored", {30'b0, ak}, 32'd0);
        read_a(rd);
        chk("R1 config after sweep", rd, model_a);
        chk("R1 B mode after sweep", {19'b0, mode_b}, {19'b0, WMASK[28:16]});

        // R5 byte select sweep
        for (int s = 0; s < 16; s++) begin
            write_a(32'hA5C3_9E7F ^ (32'h1111_1111 * s), s[3:0]);
            read_a(rd);
            chk("R5 byte select merge", rd, model_a);
            chk("R4 mode port", {19'b0, mode_a}, {19'b0, model_a[28:16]});
        end

        // R7 R8 R9 exhaustive override sweep
        for (int en = 0; en < 8; en++) begin
            for (int v = 0; v < 8; v++) begin
                write_a(32'(en) | (32'(v) << 8), 4'b0011);
                for (int f = 0; f < 16; f++) begin
                    @(negedge clk);
                    {fn_ieb, fn_oeb, fn_out, pin} = f[3:0];
                    #1;
                    chk("R8 R7 pad oeb", {31'b0, oeb_a}, {31'b0, en[0] ? v[0] : f[2]});
                    chk("R8 R7 pad out", {31'b0, out_a}, {31'b0, en[1] ? v[1] : f[1]});
                    chk("R8 R7 fn in",   {31'b0, fin_a}, {31'b0, en[2] ? v[2] : f[0]});
                    chk("R9 ieb passes", {31'b0, ieb_a}, {31'b0, f[3]});
                end
                read_a(rd);
                chk("R10 R4 override readback", rd, model_a | (32'(pin) << 15));
            end
        end

        // R2 held request acknowledges every other cycle
        @(negedge clk);
        cyc = 1; stb = 1; we = 0; adr = BASE + 4*IDX_A; sel = 4'hF;
        ackcnt = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk("R2 held request pattern", {31'b0, ack_a}, {31'b0, c[0] == 1'b0});
            if (ack_a) ackcnt++;
        end
        cyc = 0; stb = 0;
        chk("R2 ack count", 32'(ackcnt), 32'd3);
        @(negedge clk);
        stb = 1; cyc = 0;
        @(negedge clk);
        chk("R2 stb without cyc", {31'b0, ack_bus}, 32'd0);
        stb = 0;

        // R6 reset mid-run
        write_a(32'h0000_0707, 4'hF);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        model_a = {3'b0, RMODE_A, 16'h0};
        fn_oeb = 1; fn_out = 0; pin = 1;
        #1;
        chk("R6 overrides cleared oeb", {31'b0, oeb_a}, 32'd1);
        chk("R6 overrides cleared in", {31'b0, fin_a}, 32'd1);
        read_a(rd);
        chk("R6 reset restores config", rd, model_a | 32'h8000);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule